// File: doc/BRIEF.md
# Interrupt Sequencer with Return Stack and Context Shadow

This block gathers interrupt events from a handful of synchronous core sources and from three groups of asynchronous peripheral sources. Every event is captured in a flag bit that stays set until software clears it, whether or not any enable is on. A source is allowed to redirect the processor only when the global enable and its own enable are set; peripheral sources also need the peripheral-group enable.

When a qualified request is pending and the sequencer is idle, it runs a fixed entry sequence. It clears the global enable, pushes the current program counter onto an internal return stack and copies the critical context into a single shadow register, all on one edge. It then pulses a flush of the prefetched instruction and loads the fixed vector address. A return request pops the stack, drives the popped address together with the shadowed context back to the core, and sets the global enable again. Software reads and writes enables and flags through a small register port with one cycle of read latency.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the global enable, the peripheral-group enable, every per-source enable and every flag read as zero, and flush, pc_load, ctx_restore, stk_ovf and stk_unf are low.
- R2: A core source starts an entry only when the global enable and its enable are set. A peripheral source also needs the peripheral-group enable.
- R3: A flag is set by its event under any enable state. Register map (reg_addr): 0 = control (bit 7 global enable, bit 6 peripheral-group enable, bits 3:0 core enables); 1 = core flags in bits 3:0; 2, 3, 4 = enables of peripheral groups 0, 1, 2; 5, 6, 7 = flags of those groups. Peripheral input bit g*8+b maps to bit b of group g. reg_rdata shows the addressed register one clock after the address is applied.
- R4: On the edge that takes an interrupt, the global enable clears, cpu_pc is pushed and cpu_ctx is saved. In the next cycle flush is high for one cycle. In the cycle after that, pc_load is high with pc_next = 0x0004.
- R5: While the global enable is clear, events raise flags but cause no entry. A pending qualified flag starts an entry once software sets the global enable.
- R6: A ret_req while idle with a non-empty stack gives, in the next cycle, pc_load with pc_next equal to the popped address and ctx_restore high with ctx_out equal to the saved context. The global enable is set at the end of that cycle.
- R7: A flag left set through a return causes the interrupt to be taken again.
- R8: For a core event sampled on clock edge k, flush is high after edge k+1 and pc_load is high after edge k+2.
- R9: A peripheral input passes a two-flop synchronizer and a rising-edge detector. For a level first sampled high on edge k, flush is high after edge k+3 and pc_load is high after edge k+4.
- R10: A register write that clears a flag on the same edge as an event for that flag leaves the flag set.
- R11: The return stack holds 16 entries. A push when full is dropped and pulses stk_ovf for one cycle. A return with an empty stack pulses stk_unf, produces no pc_load or ctx_restore, and leaves the global enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_evt | input | 4 | Synchronous core event pulses |
| per_evt | input | 24 | Asynchronous peripheral event levels, three groups of 8 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_pc | input | 15 | Current program counter from the core |
| cpu_ctx | input | 32 | Critical registers from the core |
| ret_req | input | 1 | Return-from-interrupt request |
| flush | output | 1 | Discard the prefetched instruction |
| pc_load | output | 1 | Load pc_next into the program counter |
| pc_next | output | 15 | Vector or return address |
| ctx_restore | output | 1 | Load ctx_out into the critical registers |
| ctx_out | output | 32 | Shadowed context |
| stk_ovf | output | 1 | Push into a full stack |
| stk_unf | output | 1 | Pop from an empty stack |

## Verification
The qualification logic is driven from a table that pairs global, group and per-source enable settings with core and peripheral events. Entries separate a missing global enable, a missing group enable, a wrong per-source bit and the fully enabled case, and each one also shows that the flag was set. Directed cases time the entry for a core pulse and for an asynchronous level. They also run a return with altered core state to show that the pushed address and the saved context come back, and they cover deferred service, a retake after an uncleared flag, a clear that races an event, and filling and then over-draining the stack.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_VECTOR,
    ST_RESTORE
  } seq_state_e;

  localparam int REG_CTL      = 0;
  localparam int REG_CORE_FLG = 1;
  localparam int REG_PEN_BASE = 2;
  localparam int REG_PFL_BASE = 5;
  localparam int BIT_GEN      = 7;
  localparam int BIT_PGEN     = 6;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise[i] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_pkg::*;
#(
  parameter int NC = 4,
  parameter int NG = 3,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NC-1:0]  core_evt,
  input  logic [NG*DW-1:0] per_rise,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           gen_clr,
  input  logic           gen_set,
  output logic [DW-1:0]  reg_rdata,
  output logic           gen,
  output logic           pending
);
  localparam int NPS = NG * DW;

  logic          gen_q, pgen_q;
  logic [NC-1:0] cen_q, cflg_q;
  logic [NPS-1:0] pen_flat, pflg_flat;

  wire wr_ctl  = reg_wr && (reg_addr == AW'(REG_CTL));
  wire wr_cflg = reg_wr && (reg_addr == AW'(REG_CORE_FLG));

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= 1'b0;
      pgen_q <= 1'b0;
      cen_q  <= '0;
    end else begin
      if (wr_ctl) begin
        gen_q  <= reg_wdata[BIT_GEN];
        pgen_q <= reg_wdata[BIT_PGEN];
        cen_q  <= reg_wdata[NC-1:0];
      end
      if (gen_clr)      gen_q <= 1'b0;
      else if (gen_set) gen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cflg_q <= '0;
    else     cflg_q <= (wr_cflg ? reg_wdata[NC-1:0] : cflg_q) | core_evt;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [DW-1:0] en_q, flg_q;
    wire wr_en_g  = reg_wr && (reg_addr == AW'(REG_PEN_BASE + g));
    wire wr_flg_g = reg_wr && (reg_addr == AW'(REG_PFL_BASE + g));
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q  <= '0;
        flg_q <= '0;
      end else begin
        if (wr_en_g) en_q <= reg_wdata;
        flg_q <= (wr_flg_g ? reg_wdata : flg_q) | per_rise[g*DW +: DW];
      end
    end
    assign pen_flat[g*DW +: DW]  = en_q;
    assign pflg_flat[g*DW +: DW] = flg_q;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(REG_CTL)) begin
      rd_mux[NC-1:0]   = cen_q;
      rd_mux[BIT_GEN]  = gen_q;
      rd_mux[BIT_PGEN] = pgen_q;
    end
    if (reg_addr == AW'(REG_CORE_FLG)) rd_mux[NC-1:0] = cflg_q;
    for (int g = 0; g < NG; g++) begin
      if (reg_addr == AW'(REG_PEN_BASE + g)) rd_mux = pen_flat[g*DW +: DW];
      if (reg_addr == AW'(REG_PFL_BASE + g)) rd_mux = pflg_flat[g*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign gen     = gen_q;
  assign pending = (|(cflg_q & cen_q)) | (pgen_q & (|(pflg_flat & pen_flat)));
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int W     = 15,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[cnt_q[PW-1:0]] <= push_data;
    if (do_pop)  pop_data <= mem[PW'(cnt_q - CW'(1))];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (do_push)     cnt_q <= cnt_q + CW'(1);
      else if (do_pop) cnt_q <= cnt_q - CW'(1);
      ovf <= push && full;
      unf <= pop && empty;
    end
  end
endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         save,
  input  logic [W-1:0] save_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (save) q <= save_data;
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int NC        = 4,
  parameter int NG        = 3,
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter int PCW       = 15,
  parameter int CTXW      = 32,
  parameter int STK_DEPTH = 16,
  parameter logic [PCW-1:0] VEC = PCW'(4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NC-1:0]    core_evt,
  input  logic [NG*DW-1:0] per_evt,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [PCW-1:0]   cpu_pc,
  input  logic [CTXW-1:0]  cpu_ctx,
  input  logic             ret_req,
  output logic             flush,
  output logic             pc_load,
  output logic [PCW-1:0]   pc_next,
  output logic             ctx_restore,
  output logic [CTXW-1:0]  ctx_out,
  output logic             stk_ovf,
  output logic             stk_unf
);
  seq_state_e state_q, state_d;
  logic [NG*DW-1:0] per_rise;
  logic gen_q, pending, stk_empty;
  logic [PCW-1:0] stk_data;

  wire idle   = (state_q == ST_IDLE);
  wire take   = idle && !ret_req && gen_q && pending;
  wire do_ret = idle && ret_req;

  irq_edge_sync #(.W(NG*DW)) u_sync (
    .clk(clk), .rst(rst), .async_in(per_evt), .rise(per_rise)
  );

  irq_src_regs #(.NC(NC), .NG(NG), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .core_evt(core_evt), .per_rise(per_rise),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .gen_clr(take), .gen_set(state_q == ST_RESTORE),
    .reg_rdata(reg_rdata), .gen(gen_q), .pending(pending)
  );

  irq_ret_stack #(.W(PCW), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(take), .push_data(cpu_pc),
    .pop(do_ret), .pop_data(stk_data), .empty(stk_empty),
    .ovf(stk_ovf), .unf(stk_unf)
  );

  irq_ctx_shadow #(.W(CTXW)) u_shadow (
    .clk(clk), .rst(rst), .save(take), .save_data(cpu_ctx), .q(ctx_out)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (take)                     state_d = ST_FLUSH;
        else if (do_ret && !stk_empty) state_d = ST_RESTORE;
      end
      ST_FLUSH:   state_d = ST_VECTOR;
      ST_VECTOR:  state_d = ST_IDLE;
      ST_RESTORE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign flush       = (state_q == ST_FLUSH);
  assign pc_load     = (state_q == ST_VECTOR) || (state_q == ST_RESTORE);
  assign ctx_restore = (state_q == ST_RESTORE);
  assign pc_next     = (state_q == ST_VECTOR) ? VEC : stk_data;
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int PCW = 15,
  parameter logic [PCW-1:0] VEC = PCW'(4)
) (
  input logic           clk,
  input logic           rst,
  input logic           flush,
  input logic           pc_load,
  input logic [PCW-1:0] pc_next,
  input logic           ctx_restore,
  input logic           gen,
  input logic           stk_ovf,
  input logic           stk_unf
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flush && !pc_load && !ctx_restore));

  a_r2_no_entry_without_gen: assert property (@(posedge clk) disable iff (rst)
    !gen |=> !flush);

  a_r4_gen_low_in_flush: assert property (@(posedge clk) disable iff (rst)
    flush |-> !gen);

  a_r4_vector_after_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pc_load && !ctx_restore && pc_next == VEC));

  a_r4_flush_not_with_load: assert property (@(posedge clk) disable iff (rst)
    !(flush && pc_load));

  a_r6_restore_loads_pc: assert property (@(posedge clk) disable iff (rst)
    ctx_restore |-> pc_load);

  a_r6_gen_after_restore: assert property (@(posedge clk) disable iff (rst)
    ctx_restore |=> gen);

  a_r11_ovf_single: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> !stk_ovf);

  a_r11_unf_no_load: assert property (@(posedge clk) disable iff (rst)
    stk_unf |-> (!pc_load && !ctx_restore));
endmodule

bind irq_sequencer irq_sequencer_chk #(.PCW(PCW), .VEC(VEC)) i_chk (
  .clk(clk), .rst(rst), .flush(flush), .pc_load(pc_load), .pc_next(pc_next),
  .ctx_restore(ctx_restore), .gen(gen_q), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
);

// File: tb/test_irq_sequencer.sv
module test_irq_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  core_evt = '0;
  logic [23:0] per_evt = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [14:0] cpu_pc = '0;
  logic [31:0] cpu_ctx = '0;
  logic        ret_req = 1'b0;
  logic        flush, pc_load, ctx_restore, stk_ovf, stk_unf;
  logic [14:0] pc_next;
  logic [31:0] ctx_out;

  int n_chk = 0, n_err = 0;
  int n_flush = 0, n_load = 0, n_ovf = 0, n_unf = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_sequencer i_irq_sequencer (
    .clk(clk), .rst(rst), .core_evt(core_evt), .per_evt(per_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_pc(cpu_pc), .cpu_ctx(cpu_ctx),
    .ret_req(ret_req), .flush(flush), .pc_load(pc_load), .pc_next(pc_next),
    .ctx_restore(ctx_restore), .ctx_out(ctx_out),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (flush)   n_flush++;
      if (pc_load) n_load++;
      if (stk_ovf) n_ovf++;
      if (stk_unf) n_unf++;
    end
  end

  // {gen, pgen, core_en[3:0], grp0_en[7:0], is_periph, idx[2:0], expect_entry}
  localparam logic [18:0] TAB [8] = '{
    {1'b1, 1'b0, 4'h1, 8'h00, 1'b0, 3'd0, 1'b1},
    {1'b0, 1'b0, 4'hF, 8'h00, 1'b0, 3'd1, 1'b0},
    {1'b1, 1'b1, 4'h0, 8'h00, 1'b0, 3'd2, 1'b0},
    {1'b1, 1'b0, 4'h0, 8'hFF, 1'b1, 3'd3, 1'b0},
    {1'b1, 1'b1, 4'h0, 8'h08, 1'b1, 3'd3, 1'b1},
    {1'b1, 1'b1, 4'h0, 8'hF7, 1'b1, 3'd3, 1'b0},
    {1'b0, 1'b1, 4'h0, 8'hFF, 1'b1, 3'd5, 1'b0},
    {1'b1, 1'b0, 4'h8, 8'h00, 1'b0, 3'd3, 1'b1}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic core_pulse(int idx);
    @(negedge clk);
    core_evt[idx] = 1'b1;
    @(negedge clk);
    core_evt = '0;
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base, lbase;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk("R1 outputs", {flush, pc_load, ctx_restore, stk_ovf, stk_unf}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register", v, 0);
    end

    // Table walk: R2 qualification, R3 flag capture
    for (int i = 0; i < 8; i++) begin
      logic [18:0] e;
      e = TAB[i];
      wr(3'd0, {e[18], e[17], 2'b00, e[16:13]});
      wr(3'd2, e[12:5]);
      base = n_flush;
      if (!e[4]) core_pulse(int'(e[3:1]));
      else begin
        @(negedge clk);
        per_evt[e[3:1]] = 1'b1;
        tick(3);
        per_evt = '0;
      end
      tick(8);
      chk("R2 entry count", n_flush - base, {63'd0, e[0]});
      rd(e[4] ? 3'd5 : 3'd1, v);
      chk("R3 flag set", v[e[3:1]], 1);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h00);
      if (e[0]) begin
        do_ret();
        tick(3);
      end
      wr(3'd0, 8'h00);
      wr(3'd2, 8'h00);
    end

    // R4, R6, R8: timing of entry, vector, return and context
    cpu_pc = 15'h1234; cpu_ctx = 32'hCAFE0001;
    wr(3'd0, 8'h81);
    @(negedge clk); core_evt[0] = 1'b1;
    @(negedge clk); core_evt = '0;
    chk("R8 no flush after edge k", flush, 0);
    @(negedge clk);
    chk("R8 flush after edge k+1", flush, 1);
    chk("R4 no load during flush", pc_load, 0);
    @(negedge clk);
    chk("R8 pc_load after edge k+2", pc_load, 1);
    chk("R4 vector address", pc_next, 15'h0004);
    chk("R4 flush single cycle", flush, 0);
    cpu_pc = 15'h0555; cpu_ctx = 32'h0;
    rd(3'd0, v);
    chk("R4 global enable cleared", v[7], 0);
    wr(3'd1, 8'h00);
    do_ret();
    chk("R6 restore strobe", ctx_restore, 1);
    chk("R6 pc_load on return", pc_load, 1);
    chk("R6 popped address", pc_next, 15'h1234);
    chk("R6 shadow context", ctx_out, 32'hCAFE0001);
    rd(3'd0, v);
    chk("R6 global enable set", v[7], 1);
    wr(3'd0, 8'h00);

    // R9: asynchronous path, group 1 bit 0 (input 8)
    wr(3'd0, 8'hC0);
    wr(3'd3, 8'h01);
    @(negedge clk); per_evt[8] = 1'b1;
    tick(3);
    chk("R9 no flush after edge k+2", flush, 0);
    tick(1);
    chk("R9 flush after edge k+3", flush, 1);
    tick(1);
    chk("R9 pc_load after edge k+4", pc_load, 1);
    per_evt = '0;
    wr(3'd6, 8'h00);
    do_ret();
    tick(3);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h00);

    // R5: deferred service while global enable is clear
    wr(3'd0, 8'h01);
    base = n_flush;
    core_pulse(0);
    tick(6);
    chk("R5 no entry with gen clear", n_flush - base, 0);
    rd(3'd1, v);
    chk("R5 flag recorded", v[0], 1);
    wr(3'd0, 8'h81);
    tick(5);
    chk("R5 entry after gen set", n_flush - base, 1);
    wr(3'd1, 8'h00);
    do_ret();
    tick(3);
    wr(3'd0, 8'h00);

    // R7: uncleared flag is taken again after return
    wr(3'd0, 8'h81);
    base = n_flush;
    core_pulse(0);
    tick(5);
    chk("R7 first entry", n_flush - base, 1);
    do_ret();
    tick(6);
    chk("R7 retaken after return", n_flush - base, 2);
    wr(3'd1, 8'h00);
    do_ret();
    tick(3);
    wr(3'd0, 8'h00);

    // R10: clear write racing a new event
    core_pulse(0);
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1'b1; core_evt[1] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; core_evt = '0;
    rd(3'd1, v);
    chk("R10 racing event kept, other cleared", v, 8'h02);
    wr(3'd1, 8'h00);

    // R11: overflow on 17th nested entry, underflow on 17th return
    cpu_pc = 15'h0777;
    wr(3'd0, 8'h01);
    core_pulse(0);
    base = n_flush;
    for (int k = 0; k < 17; k++) begin
      wr(3'd0, 8'h81);
      tick(4);
      if (k == 15) chk("R11 no overflow at 16", n_ovf, 0);
    end
    chk("R11 entries", n_flush - base, 17);
    chk("R11 overflow pulse", n_ovf, 1);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    for (int k = 0; k < 16; k++) begin
      do_ret();
      tick(2);
    end
    chk("R11 no underflow after 16 pops", n_unf, 0);
    lbase = n_load;
    do_ret();
    tick(3);
    chk("R11 underflow pulse", n_unf, 1);
    chk("R11 no load on empty pop", n_load - lbase, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule